// File: doc/BRIEF.md
# Tomasulo Reservation Station Unit

This block is the group of reservation stations that sits in front of one pipelined arithmetic unit in an out-of-order core. The front end sends it at most one instruction per cycle, in program order. Each instruction carries an operation and two sources. Every source is either a value that is already known or the tag of the station that will produce it. The block gives the instruction a tag, which is the station's global index, and the rename logic records that tag.

While an instruction waits, each pending source watches every result bus in the machine. When a bus carries the awaited tag, the source takes the value. Once both sources are present, the instruction can issue. The unit issues the oldest waiting instruction that is ready. The arithmetic pipeline is fully pipelined: an add takes two cycles and a multiply takes four. When the result is broadcast, the station that held the instruction is released. A flush discards all stations and all work in flight.

Top module: `rs_unit`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, every station is free: `disp_ready` is 1, `iss_valid` is 0 and `res_valid` is 0. Results that were in flight are never broadcast, and a dispatch made in the flush cycle is dropped.
- R2: A dispatch goes into the free station with the lowest index. `disp_tag` shows the tag that station will use, which is `TAG_BASE` plus its index.
- R3: `disp_ready` is 0 exactly when all `NE` stations are occupied. A dispatch offered while it is 0 is ignored.
- R4: A pending source takes the data of a bus whose valid bit is set and whose tag equals the source's stored tag. It keeps its tag and does not capture again. The instruction can issue in the cycle after its last source arrives.
- R5: A pending source whose tag is on a bus in the same cycle as its dispatch takes the value at dispatch.
- R6: When several stations can issue, the one dispatched earliest issues, whatever its index. `iss_tag` shows its tag.
- R7: `disp_op` 0 is an add, giving a+b mod 2^DW two cycles after issue. `disp_op` 1 is a multiply, giving the low DW bits of a*b four cycles after issue. The result appears for one cycle on `res_valid`/`res_tag`/`res_data`.
- R8: A station stays occupied until the cycle in which its result is broadcast, and it is free from the next cycle on.
- R9: An add does not issue two cycles after a multiply issued, because both results would be due in the same cycle. A younger ready multiply may issue in its place.
- R10: The value field of a source dispatched as pending is ignored. Only the captured bus data enters the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clears all stations and the pipeline |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A station is free |
| disp_tag | output | TW | Tag given to the dispatched instruction |
| disp_op | input | 1 | 0 add, 1 multiply |
| disp_a_ok | input | 1 | Source A value is present |
| disp_a_tag | input | TW | Source A producer tag when pending |
| disp_a_val | input | DW | Source A value when present |
| disp_b_ok | input | 1 | Source B value is present |
| disp_b_tag | input | TW | Source B producer tag when pending |
| disp_b_val | input | DW | Source B value when present |
| bc_valid | input | NB | Per-bus broadcast valid |
| bc_tag | input | NB*TW | Per-bus tags, bus k at bits k*TW |
| bc_data | input | NB*DW | Per-bus data, bus k at bits k*DW |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_tag | output | TW | Tag of the issuing instruction |
| res_valid | output | 1 | Result broadcast valid |
| res_tag | output | TW | Tag of the broadcast result |
| res_data | output | DW | Broadcast result value |

## Verification
The bench targets the following corner cases:
- Stations that are freed and then refilled, so that a low index can hold a younger instruction. A selector that picked by index would issue out of age order.
- A source whose producer broadcasts in the very cycle of dispatch. Missing this case would leave the instruction waiting forever.
- An add that becomes ready exactly two cycles after a multiply issued. A unit without the slot rule would issue it and lose or corrupt one of the two results.
- A flush with a multiply in flight, which must not surface afterwards.
- Dispatch attempts while the unit is full, which a careless design would accept by overwriting a live station.

// File: rtl/rs_unit.sv
`timescale 1ns/1ps
module rs_unit #(
  parameter int NE       = 4,
  parameter int NB       = 3,
  parameter int DW       = 16,
  parameter int TW       = 7,
  parameter int TAG_BASE = 0,
  parameter int ADD_LAT  = 2,
  parameter int MUL_LAT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             disp_valid,
  output logic             disp_ready,
  output logic [TW-1:0]    disp_tag,
  input  logic             disp_op,
  input  logic             disp_a_ok,
  input  logic [TW-1:0]    disp_a_tag,
  input  logic [DW-1:0]    disp_a_val,
  input  logic             disp_b_ok,
  input  logic [TW-1:0]    disp_b_tag,
  input  logic [DW-1:0]    disp_b_val,
  input  logic [NB-1:0]    bc_valid,
  input  logic [NB*TW-1:0] bc_tag,
  input  logic [NB*DW-1:0] bc_data,
  output logic             iss_valid,
  output logic [TW-1:0]    iss_tag,
  output logic             res_valid,
  output logic [TW-1:0]    res_tag,
  output logic [DW-1:0]    res_data
);
  localparam int IW = (NE > 1) ? $clog2(NE) : 1;
  localparam int PD = MUL_LAT;

  logic [NE-1:0] busy, issued, op, a_ok, b_ok;
  logic [TW-1:0] a_tag [NE];
  logic [TW-1:0] b_tag [NE];
  logic [DW-1:0] a_val [NE];
  logic [DW-1:0] b_val [NE];
  logic [NE-1:0] older [NE];

  logic [NE-1:0] a_hit, b_hit;
  logic [DW-1:0] a_hv [NE];
  logic [DW-1:0] b_hv [NE];
  logic          da_hit, db_hit;
  logic [DW-1:0] da_hv, db_hv;

  logic [NE-1:0] elig;
  logic [IW-1:0] alloc_idx, iss_idx;
  logic          disp_fire, add_free, iss_op;
  logic [DW-1:0] iss_a, iss_b, iss_res;

  logic [PD-1:0] pv;
  logic [IW-1:0] pidx [PD];
  logic [DW-1:0] pdat [PD];

  function automatic logic [DW:0] snoop(input logic [TW-1:0] t, input logic [NB-1:0] v,
                                        input logic [NB*TW-1:0] tg, input logic [NB*DW-1:0] d);
    logic [DW:0] r;
    r = '0;
    for (int k = 0; k < NB; k++)
      if (v[k] && tg[k*TW +: TW] == t) r = {1'b1, d[k*DW +: DW]};
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < NE; i++) begin
      {a_hit[i], a_hv[i]} = snoop(a_tag[i], bc_valid, bc_tag, bc_data);
      {b_hit[i], b_hv[i]} = snoop(b_tag[i], bc_valid, bc_tag, bc_data);
    end
    {da_hit, da_hv} = snoop(disp_a_tag, bc_valid, bc_tag, bc_data);
    {db_hit, db_hv} = snoop(disp_b_tag, bc_valid, bc_tag, bc_data);
  end

  always_comb begin
    alloc_idx = '0;
    for (int i = NE - 1; i >= 0; i--)
      if (!busy[i]) alloc_idx = IW'(i);
  end

  assign disp_ready = ~&busy;
  assign disp_fire  = disp_valid & disp_ready;
  assign disp_tag   = TW'(TAG_BASE) + TW'(alloc_idx);

  generate
    if (ADD_LAT < PD) begin : g_slot
      assign add_free = ~pv[ADD_LAT];
    end else begin : g_noslot
      assign add_free = 1'b1;
    end
  endgenerate

  assign elig = busy & ~issued & a_ok & b_ok & (op | {NE{add_free}});

  always_comb begin
    logic blk;
    iss_idx = '0;
    for (int i = 0; i < NE; i++) begin
      blk = 1'b0;
      for (int j = 0; j < NE; j++)
        if (elig[j] && older[j][i]) blk = 1'b1;
      if (elig[i] && !blk) iss_idx = IW'(i);
    end
  end

  assign iss_valid = |elig;
  assign iss_tag   = TW'(TAG_BASE) + TW'(iss_idx);
  assign iss_op    = op[iss_idx];
  assign iss_a     = a_val[iss_idx];
  assign iss_b     = b_val[iss_idx];
  assign iss_res   = iss_op ? iss_a * iss_b : iss_a + iss_b;

  assign res_valid = pv[0];
  assign res_tag   = TW'(TAG_BASE) + TW'(pidx[0]);
  assign res_data  = pdat[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0; issued <= '0; op <= '0; a_ok <= '0; b_ok <= '0; pv <= '0;
      for (int i = 0; i < NE; i++) begin
        a_tag[i] <= '0; b_tag[i] <= '0; a_val[i] <= '0; b_val[i] <= '0; older[i] <= '0;
      end
      for (int k = 0; k < PD; k++) begin
        pidx[k] <= '0; pdat[k] <= '0;
      end
    end else if (flush) begin
      busy <= '0; issued <= '0; pv <= '0;
    end else begin
      for (int k = 0; k < PD - 1; k++) begin
        pv[k] <= pv[k+1]; pidx[k] <= pidx[k+1]; pdat[k] <= pdat[k+1];
      end
      pv[PD-1] <= 1'b0;

      for (int i = 0; i < NE; i++) begin
        if (busy[i] && !a_ok[i] && a_hit[i]) begin a_ok[i] <= 1'b1; a_val[i] <= a_hv[i]; end
        if (busy[i] && !b_ok[i] && b_hit[i]) begin b_ok[i] <= 1'b1; b_val[i] <= b_hv[i]; end
      end

      if (iss_valid) begin
        issued[iss_idx] <= 1'b1;
        if (iss_op) begin
          pv[MUL_LAT-1] <= 1'b1; pidx[MUL_LAT-1] <= iss_idx; pdat[MUL_LAT-1] <= iss_res;
        end else begin
          pv[ADD_LAT-1] <= 1'b1; pidx[ADD_LAT-1] <= iss_idx; pdat[ADD_LAT-1] <= iss_res;
        end
      end

      if (pv[0]) begin
        busy[pidx[0]]   <= 1'b0;
        issued[pidx[0]] <= 1'b0;
      end

      if (disp_fire) begin
        busy[alloc_idx]   <= 1'b1;
        issued[alloc_idx] <= 1'b0;
        op[alloc_idx]     <= disp_op;
        a_tag[alloc_idx]  <= disp_a_tag;
        b_tag[alloc_idx]  <= disp_b_tag;
        a_ok[alloc_idx]   <= disp_a_ok | da_hit;
        b_ok[alloc_idx]   <= disp_b_ok | db_hit;
        a_val[alloc_idx]  <= disp_a_ok ? disp_a_val : da_hv;
        b_val[alloc_idx]  <= disp_b_ok ? disp_b_val : db_hv;
        for (int j = 0; j < NE; j++) begin
          older[alloc_idx][j] <= 1'b0;
          older[j][alloc_idx] <= busy[j];
        end
      end
    end
  end
endmodule

// File: rtl/rs_unit_chk.sv
`timescale 1ns/1ps
module rs_unit_chk #(
  parameter int NE       = 4,
  parameter int TW       = 7,
  parameter int TAG_BASE = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          disp_valid,
  input logic          disp_ready,
  input logic          iss_valid,
  input logic [TW-1:0] iss_tag,
  input logic          res_valid,
  input logic [TW-1:0] res_tag
);
  p_clear_after_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (disp_ready && !iss_valid && !res_valid));

  p_issue_tag_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (int'(iss_tag) >= TAG_BASE && int'(iss_tag) < TAG_BASE + NE));

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && !res_valid && !flush) |=> !disp_ready);

  p_one_broadcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !flush) |=> !(res_valid && res_tag == $past(res_tag)));

  p_held_until_broadcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(iss_valid && iss_tag == res_tag));

  p_ready_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !$isunknown(disp_ready));
endmodule

bind rs_unit rs_unit_chk #(.NE(NE), .TW(TW), .TAG_BASE(TAG_BASE)) u_chk (.*);

// File: tb/tb_rs_unit.sv
`timescale 1ns/1ps
module tb_rs_unit;
  localparam int NE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush;
  logic d_valid, d_op, d_aok, d_bok;
  logic [6:0] d_atag, d_btag;
  logic [15:0] d_aval, d_bval;
  logic e1v, e2v;
  logic [6:0] e1t, e2t;
  logic [15:0] e1d, e2d;

  logic disp_ready, iss_valid, res_valid;
  logic [6:0] disp_tag, iss_tag, res_tag;
  logic [15:0] res_data;
  logic [2:0] bc_valid;
  logic [20:0] bc_tag;
  logic [47:0] bc_data;

  assign bc_valid = {e2v, e1v, res_valid};
  assign bc_tag   = {e2t, e1t, res_tag};
  assign bc_data  = {e2d, e1d, res_data};

  always #4 clk = ~clk;

  rs_unit dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(d_valid), .disp_ready(disp_ready), .disp_tag(disp_tag), .disp_op(d_op),
    .disp_a_ok(d_aok), .disp_a_tag(d_atag), .disp_a_val(d_aval),
    .disp_b_ok(d_bok), .disp_b_tag(d_btag), .disp_b_val(d_bval),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .iss_valid(iss_valid), .iss_tag(iss_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, seqc = 0;
  bit clr = 1'b1, mm1 = 1'b0, mm2 = 1'b0;
  bit m_busy[NE], m_iss[NE], m_op[NE], m_ok1[NE], m_ok2[NE];
  int m_t1[NE], m_t2[NE], m_seq[NE], m_ic[NE];
  logic [15:0] m_v1[NE], m_v2[NE];

  function automatic logic [15:0] calc(input bit o, input logic [15:0] a, input logic [15:0] b);
    return o ? a * b : a + b;
  endfunction

  function automatic bit bus_hit(input int t, input int er, input logic [15:0] rv,
                                 output logic [15:0] v);
    v = '0;
    if (er >= 0 && t == er) begin v = rv; return 1'b1; end
    if (e1v && t == int'(e1t)) begin v = e1d; return 1'b1; end
    if (e2v && t == int'(e2t)) begin v = e2d; return 1'b1; end
    return 1'b0;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic idle();
    flush = 0; d_valid = 0; d_op = 0; d_aok = 0; d_bok = 0;
    d_atag = 0; d_btag = 0; d_aval = 0; d_bval = 0;
    e1v = 0; e2v = 0; e1t = 0; e2t = 0; e1d = 0; e2d = 0;
  endtask

  task automatic tick();
    int fi, best, er;
    logic [15:0] rv, tv;
    #1;
    fi = -1;
    for (int i = NE - 1; i >= 0; i--) if (!m_busy[i]) fi = i;
    chk(clr ? "R1 R3 ready" : "R3 ready", disp_ready, fi >= 0);
    if (fi >= 0) chk("R2 R8 alloc tag", disp_tag, fi);
    best = -1;
    for (int i = 0; i < NE; i++)
      if (m_busy[i] && !m_iss[i] && m_ok1[i] && m_ok2[i] && (m_op[i] || !mm2))
        if (best < 0 || m_seq[i] < m_seq[best]) best = i;
    chk(clr ? "R1 issue valid" : "R4 R5 R6 R9 issue valid", iss_valid, best >= 0);
    if (best >= 0 && iss_valid) chk("R6 oldest issue tag", iss_tag, best);
    er = -1; rv = '0;
    for (int i = 0; i < NE; i++)
      if (m_busy[i] && m_iss[i] && m_ic[i] + (m_op[i] ? 4 : 2) == cyc) er = i;
    chk(clr ? "R1 result valid" : "R7 result valid", res_valid, er >= 0);
    if (er >= 0) begin
      rv = calc(m_op[er], m_v1[er], m_v2[er]);
      if (res_valid) begin
        chk("R7 result tag", res_tag, er);
        chk("R7 R10 result data", res_data, rv);
      end
    end
    clr = 1'b0;
    if (flush) begin
      for (int i = 0; i < NE; i++) begin m_busy[i] = 0; m_iss[i] = 0; end
      mm1 = 0; mm2 = 0; clr = 1'b1;
    end else begin
      for (int i = 0; i < NE; i++) if (m_busy[i]) begin
        if (!m_ok1[i] && bus_hit(m_t1[i], er, rv, tv)) begin m_ok1[i] = 1; m_v1[i] = tv; end
        if (!m_ok2[i] && bus_hit(m_t2[i], er, rv, tv)) begin m_ok2[i] = 1; m_v2[i] = tv; end
      end
      if (d_valid && fi >= 0) begin
        m_busy[fi] = 1; m_iss[fi] = 0; m_op[fi] = d_op; m_seq[fi] = seqc++;
        m_t1[fi] = int'(d_atag); m_t2[fi] = int'(d_btag);
        if (d_aok) begin m_ok1[fi] = 1; m_v1[fi] = d_aval; end
        else begin m_ok1[fi] = bus_hit(m_t1[fi], er, rv, tv); m_v1[fi] = tv; end
        if (d_bok) begin m_ok2[fi] = 1; m_v2[fi] = d_bval; end
        else begin m_ok2[fi] = bus_hit(m_t2[fi], er, rv, tv); m_v2[fi] = tv; end
      end
      if (er >= 0) begin m_busy[er] = 0; m_iss[er] = 0; end
      if (best >= 0) begin m_iss[best] = 1; m_ic[best] = cyc; end
      mm2 = mm1;
      mm1 = (best >= 0) && m_op[best];
    end
    cyc++;
    @(negedge clk);
  endtask

  function automatic logic [6:0] pick_tag();
    int j;
    j = int'($urandom % NE);
    if (($urandom % 2) != 0 && m_busy[j]) return 7'(j);
    return 7'(20 + ($urandom % 4));
  endfunction

  task automatic rnd();
    d_valid = ($urandom % 3) != 0;
    d_op    = 1'($urandom % 2);
    d_aok   = 1'($urandom % 2);
    d_bok   = 1'($urandom % 2);
    d_aval  = 16'($urandom);
    d_bval  = 16'($urandom);
    d_atag  = pick_tag();
    d_btag  = pick_tag();
    e1v = ($urandom % 4) == 0;
    e1t = 7'(20 + ($urandom % 4));
    e1d = 16'($urandom);
    e2v = ($urandom % 4) == 0;
    e2t = 7'(20 + ((int'(e1t) - 20 + 1 + int'($urandom % 3)) % 4));
    e2d = 16'($urandom);
    flush = ($urandom % 400) == 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NE; i++) begin
      m_busy[i] = 0; m_iss[i] = 0; m_op[i] = 0; m_ok1[i] = 0; m_ok2[i] = 0;
      m_t1[i] = 0; m_t2[i] = 0; m_seq[i] = 0; m_ic[i] = 0; m_v1[i] = 0; m_v2[i] = 0;
    end
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(); tick();

    // R2 R3: fill all stations with adds waiting on tag 30, then offer one more
    for (int k = 0; k < NE; k++) begin
      idle(); d_valid = 1; d_atag = 30; d_aval = 16'hdead; d_bok = 1; d_bval = 16'(k + 1);
      tick();
    end
    idle(); d_valid = 1; d_aok = 1; d_bok = 1; d_aval = 7; d_bval = 9;
    tick();
    // R4: one broadcast wakes all four
    idle(); e1v = 1; e1t = 30; e1d = 16'h0100;
    tick();
    idle(); repeat (12) tick();

    // R5: producer broadcasts in the dispatch cycle
    idle(); d_valid = 1; d_op = 1; d_atag = 21; d_bok = 1; d_bval = 3;
    e1v = 1; e1t = 21; e1d = 5;
    tick();
    idle(); #1 chk("R5 same-cycle capture issues next cycle", iss_valid, 1);
    tick();
    repeat (6) tick();

    // R9: add ready two cycles after a multiply issued
    idle(); d_valid = 1; d_op = 1; d_aok = 1; d_bok = 1; d_aval = 2; d_bval = 3;
    tick();
    idle(); d_valid = 1; d_atag = 25; d_bok = 1; d_bval = 1;
    tick();
    idle(); e1v = 1; e1t = 25; e1d = 4;
    tick();
    idle(); #1 chk("R9 add held for result slot", iss_valid, 0);
    tick();
    idle(); #1 chk("R9 add issues a cycle later", iss_valid, 1);
    tick();
    repeat (6) tick();

    // R1: flush with a multiply in flight
    idle(); d_valid = 1; d_op = 1; d_aok = 1; d_bok = 1; d_aval = 9; d_bval = 9;
    tick();
    idle(); tick();
    idle(); flush = 1;
    tick();
    idle(); repeat (6) tick();

    for (int n = 0; n < 4000; n++) begin
      rnd();
      tick();
    end
    idle(); repeat (20) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule